// File: doc/BRIEF.md
# CPU exception entry sequencer

This block carries out the hardware side of entering and leaving an exception for a 32-bit RISC pipeline. It handles two exception kinds: the address exception and the floating-point exception. A floating-point request is passed through a qualifier that compares its cause bits against the enable bits of the floating-point status register. A cause that is not enabled is dropped. The unimplemented-operation cause always traps.

When an exception is accepted, the current SM, IE and C status bits are copied into the backup bits BSM, BIE and BC. The backup PC is loaded with the return address. In the next cycle the sequencer drives a one-cycle flush pulse together with the vector address. In that same cycle it writes the handler status to the pipeline: SM keeps its value, and IE and C are cleared. For an address exception the return address is rounded down to a word boundary, so the faulting instruction is fetched again after return. A return-from-exception command produces the same one-cycle redirect. Its target is the backup PC, and it writes the backup bits back into SM, IE and C.

The live status register belongs to the pipeline. The sequencer reads it on `cur_sm`, `cur_ie` and `cur_c`, and updates it through the `psw_we` write strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `flush` and `psw_we` are 0, `new_pc` is 0, and `bsm`, `bie`, `bc` and `bpc` are all 0.
- R2: A floating-point request traps only if at least one of the IEEE cause bits `fpe_cause[4:0]` is 1 and its matching enable bit `fpe_enable[4:0]` is also 1. The cause bits are bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow and bit4 inexact. A request that does not trap leaves every output and backup register unchanged.
- R3: The unimplemented-operation cause `fpe_cause[5]` makes a floating-point request trap whatever the enable bits are.
- R4: On the clock edge that accepts an exception, `bsm`, `bie` and `bc` take the values of `cur_sm`, `cur_ie` and `cur_c`.
- R5: In the cycle after an exception is accepted, `psw_we` is 1, `psw_sm` equals `bsm`, and `psw_ie` and `psw_c` are 0.
- R6: An accepted address exception loads `bpc` with `ae_pc` with its two low bits cleared. In the following cycle `new_pc` is 0x0000_0030. For example, a fault at 0x06 gives a `bpc` of 0x04.
- R7: An accepted floating-point exception loads `bpc` with `fpe_pc` unchanged. In the following cycle `new_pc` is the parameter `FPE_VECTOR`, which defaults to 0x0000_0040.
- R8: `flush` is 1 for exactly one cycle, and that cycle follows the accepting edge. When `flush` is 0, `new_pc`, `psw_sm`, `psw_ie` and `psw_c` are 0.
- R9: An accepted `rte_req` leads, in the next cycle, to `flush` and `psw_we` being 1, `new_pc` equal to `bpc`, and `psw_sm`/`psw_ie`/`psw_c` equal to `bsm`/`bie`/`bc`. The backup registers keep their values.
- R10: When `ae_req` and a trapping floating-point request arrive in the same cycle, the address exception is taken and the floating-point request is dropped. An exception also takes priority over a simultaneous `rte_req`.
- R11: Requests that arrive during the cycle in which `flush` is 1 are ignored. Backup registers do not change, and no flush follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fpe_req | input | 1 | Floating-point exception request |
| fpe_cause | input | 6 | Cause bits: [4:0] IEEE causes, [5] unimplemented operation |
| fpe_enable | input | 5 | Enable bits from the floating-point status register |
| fpe_pc | input | 32 | Return address for a floating-point exception |
| ae_req | input | 1 | Address exception request |
| ae_pc | input | 32 | Address of the faulting instruction |
| rte_req | input | 1 | Return-from-exception command |
| cur_sm | input | 1 | Current SM status bit |
| cur_ie | input | 1 | Current IE status bit |
| cur_c | input | 1 | Current C status bit |
| flush | output | 1 | One-cycle pipeline flush and redirect strobe |
| new_pc | output | 32 | Redirect target, valid with `flush` |
| psw_we | output | 1 | Write strobe for the status bits |
| psw_sm | output | 1 | SM value to write |
| psw_ie | output | 1 | IE value to write |
| psw_c | output | 1 | C value to write |
| bsm | output | 1 | Backup SM |
| bie | output | 1 | Backup IE |
| bc | output | 1 | Backup C |
| bpc | output | 32 | Backup PC |

## Verification
Floating-point requests are driven with random cause and enable masks. This separates enabled causes, masked causes and the unimplemented cause, which must trap with every enable bit at 0. Address exceptions use random addresses at all four byte offsets, which shows whether the word rounding is applied and applied only to the address path. Requests are stacked in the same cycle and placed in the redirect cycle, which tests the priority order and the window in which requests are ignored. Random status-bit values on entry and on return show whether the backup bits are truly saved and restored rather than held at a fixed value.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ENTER  = 2'd1,
    ST_RETURN = 2'd2
  } seq_state_t;

  // Round an address down to its containing 32-bit word
  function automatic logic [31:0] word_align(input logic [31:0] addr);
    return {addr[31:2], 2'b00};
  endfunction

  // Trap decision: any enabled IEEE cause, or the unimplemented cause
  function automatic logic fpe_traps(input logic [5:0] cause,
                                     input logic [4:0] enable);
    return (|(cause[4:0] & enable)) | cause[5];
  endfunction

endpackage

// File: rtl/fpe_qual.sv
module fpe_qual (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [5:0] cause,
  input  logic [4:0] enable,
  output logic       hit
);
  import exc_pkg::*;

  assign hit = req & fpe_traps(cause, enable);

  // R3
  unimpl_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cause[5]) |-> hit);

  // R2
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cause[5] && ((cause[4:0] & enable) == 5'd0)) |-> !hit);

endmodule

// File: rtl/exc_backup.sv
module exc_backup #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save,
  input  logic            in_sm,
  input  logic            in_ie,
  input  logic            in_c,
  input  logic [XLEN-1:0] in_pc,
  output logic            bsm,
  output logic            bie,
  output logic            bc,
  output logic [XLEN-1:0] bpc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsm <= 1'b0;
      bie <= 1'b0;
      bc  <= 1'b0;
      bpc <= '0;
    end else if (save) begin
      bsm <= in_sm;
      bie <= in_ie;
      bc  <= in_c;
      bpc <= in_pc;
    end
  end

  // R4
  backup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> (bsm == $past(in_sm) && bie == $past(in_ie) && bc == $past(in_c)));

  // R11
  backup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save |=> $stable(bpc) && $stable(bsm) && $stable(bie) && $stable(bc));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int          XLEN       = 32,
  parameter logic [31:0] AE_VECTOR  = 32'h0000_0030,
  parameter logic [31:0] FPE_VECTOR = 32'h0000_0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fpe_req,
  input  logic [5:0]  fpe_cause,
  input  logic [4:0]  fpe_enable,
  input  logic [31:0] fpe_pc,
  input  logic        ae_req,
  input  logic [31:0] ae_pc,
  input  logic        rte_req,
  input  logic        cur_sm,
  input  logic        cur_ie,
  input  logic        cur_c,
  output logic        flush,
  output logic [31:0] new_pc,
  output logic        psw_we,
  output logic        psw_sm,
  output logic        psw_ie,
  output logic        psw_c,
  output logic        bsm,
  output logic        bie,
  output logic        bc,
  output logic [31:0] bpc
);
  import exc_pkg::*;

  seq_state_t      state_q, state_d;
  logic [XLEN-1:0] target_q, target_d;
  logic            fpe_hit;
  logic            idle, ae_take, fpe_take, rte_take, save;
  logic [XLEN-1:0] save_pc;

  fpe_qual u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (fpe_req),
    .cause  (fpe_cause),
    .enable (fpe_enable),
    .hit    (fpe_hit)
  );

  // Named acceptance events
  assign idle     = (state_q == ST_IDLE);
  assign ae_take  = idle & ae_req;
  assign fpe_take = idle & ~ae_req & fpe_hit;
  assign rte_take = idle & ~ae_req & ~fpe_hit & rte_req;
  assign save     = ae_take | fpe_take;
  assign save_pc  = ae_take ? word_align(ae_pc) : fpe_pc;

  exc_backup #(.XLEN(XLEN)) u_backup (
    .clk   (clk),
    .rst_n (rst_n),
    .save  (save),
    .in_sm (cur_sm),
    .in_ie (cur_ie),
    .in_c  (cur_c),
    .in_pc (save_pc),
    .bsm   (bsm),
    .bie   (bie),
    .bc    (bc),
    .bpc   (bpc)
  );

  always_comb begin
    state_d  = ST_IDLE;
    target_d = target_q;
    if (ae_take) begin
      state_d  = ST_ENTER;
      target_d = AE_VECTOR;
    end else if (fpe_take) begin
      state_d  = ST_ENTER;
      target_d = FPE_VECTOR;
    end else if (rte_take) begin
      state_d  = ST_RETURN;
      target_d = bpc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
    end
  end

  assign flush  = (state_q != ST_IDLE);
  assign psw_we = flush;
  assign new_pc = flush ? target_q : '0;
  assign psw_sm = flush & bsm;
  assign psw_ie = (state_q == ST_RETURN) & bie;
  assign psw_c  = (state_q == ST_RETURN) & bc;

  // R8
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R6
  ae_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae_take |=> (flush && new_pc == AE_VECTOR && bpc[1:0] == 2'b00));

  // R5
  entry_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> (psw_we && !psw_ie && !psw_c && psw_sm == bsm));

  // R9
  rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rte_take |=> (flush && new_pc == bpc && psw_ie == bie && psw_c == bc));

  // R10
  ae_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ae_req && fpe_hit) |=> (new_pc == AE_VECTOR));

endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam logic [31:0] AEV = 32'h0000_0030;
  localparam logic [31:0] FPV = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fpe_req = 0, ae_req = 0, rte_req = 0;
  logic [5:0]  fpe_cause = 0;
  logic [4:0]  fpe_enable = 0;
  logic [31:0] fpe_pc = 0, ae_pc = 0;
  logic        cur_sm = 0, cur_ie = 0, cur_c = 0;
  logic        flush, psw_we, psw_sm, psw_ie, psw_c, bsm, bie, bc;
  logic [31:0] new_pc, bpc;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_busy = 0;
  bit m_bsm = 0, m_bie = 0, m_bc = 0;
  logic [31:0] m_bpc = 0;

  always #4 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .fpe_req(fpe_req), .fpe_cause(fpe_cause),
    .fpe_enable(fpe_enable), .fpe_pc(fpe_pc), .ae_req(ae_req), .ae_pc(ae_pc),
    .rte_req(rte_req), .cur_sm(cur_sm), .cur_ie(cur_ie), .cur_c(cur_c),
    .flush(flush), .new_pc(new_pc), .psw_we(psw_we), .psw_sm(psw_sm),
    .psw_ie(psw_ie), .psw_c(psw_c), .bsm(bsm), .bie(bie), .bc(bc), .bpc(bpc));

  function automatic bit traps(input logic [5:0] c, input logic [4:0] e);
    bit t = c[5];
    for (int i = 0; i < 5; i++) if (c[i] && e[i]) t = 1;
    return t;
  endfunction

  function automatic logic [71:0] pack_out(input bit f, input bit we,
      input bit s, input bit i, input bit c, input bit b0, input bit b1,
      input bit b2, input logic [31:0] np, input logic [31:0] bp);
    return {f, we, s, i, c, b0, b1, b2, np, bp};
  endfunction

  task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Apply one cycle of inputs (at negedge), compare at the next negedge
  task automatic cycle(input bit fr, input logic [5:0] fc, input logic [4:0] fe,
      input logic [31:0] fp, input bit ar, input logic [31:0] ap, input bit rr,
      input bit s, input bit i, input bit c);
    bit ef = 0, ewe = 0, es = 0, ei = 0, ec = 0;
    logic [31:0] enp = 0;
    string tag;
    fpe_req = fr; fpe_cause = fc; fpe_enable = fe; fpe_pc = fp;
    ae_req = ar; ae_pc = ap; rte_req = rr; cur_sm = s; cur_ie = i; cur_c = c;
    tag = "R2";
    if (m_busy) begin
      tag = "R11"; m_busy = 0;
    end else if (ar) begin
      tag = fr ? "R10" : "R6";
      m_bsm = s; m_bie = i; m_bc = c; m_bpc = ap & 32'hFFFF_FFFC;
      ef = 1; ewe = 1; es = s; enp = AEV; m_busy = 1;
    end else if (fr && traps(fc, fe)) begin
      tag = (fc[5] && fe == 0) ? "R3" : "R7";
      m_bsm = s; m_bie = i; m_bc = c; m_bpc = fp;
      ef = 1; ewe = 1; es = s; enp = FPV; m_busy = 1;
    end else if (rr) begin
      tag = "R9";
      ef = 1; ewe = 1; es = m_bsm; ei = m_bie; ec = m_bc; enp = m_bpc; m_busy = 1;
    end
    @(posedge clk);
    @(negedge clk);
    // R4 R5 R8 covered by every compare of backups and status writes
    check(tag, pack_out(flush, psw_we, psw_sm, psw_ie, psw_c, bsm, bie, bc, new_pc, bpc),
          pack_out(ef, ewe, es, ei, ec, m_bsm, m_bie, m_bc, enp, m_bpc));
  endtask

  task automatic idle1();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pack_out(flush, psw_we, psw_sm, psw_ie, psw_c, bsm, bie, bc, new_pc, bpc), 72'd0);
    rst_n = 1'b1;
    idle1();
    // R6: fault at byte +2 of word 0x04
    cycle(0, 0, 0, 0, 1, 32'h0000_0006, 0, 1, 1, 1);
    idle1();
    // R9: return restores
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle1();
    // R2: masked cause dropped
    cycle(1, 6'b000100, 5'b11011, 32'h100, 0, 0, 0, 1, 1, 0);
    // R3: unimplemented with all enables cleared
    cycle(1, 6'b100000, 5'b00000, 32'h0000_1232, 0, 0, 0, 0, 1, 1);
    // R11: request during redirect cycle ignored
    cycle(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 1, 1, 0, 1);
    idle1();
    // R10: address exception beats floating-point request
    cycle(1, 6'b100001, 5'b11111, 32'h500, 1, 32'h0000_2003, 1, 0, 1, 0);
    idle1();
    // R7: enabled IEEE cause
    cycle(1, 6'b010000, 5'b10000, 32'h0000_7777, 0, 0, 0, 1, 0, 0);
    idle1();
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      cycle(($urandom % 3) == 0, 6'($urandom), 5'($urandom), $urandom,
            ($urandom % 6) == 0, $urandom, ($urandom % 4) == 0,
            1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule